// File: doc/BRIEF.md
# Asynchronous Byte-FIFO Bus Master

This block is the FPGA-side master for an external USB byte FIFO chip. The chip has an 8-bit data bus that carries traffic in both directions and four handshake lines. Two flags come from the chip. One is low while at least one received byte is waiting. The other is low while the chip can accept a byte. The master drives two strobes. An active-low read strobe makes the chip put its current byte on the bus, and releasing the strobe advances the chip to its next byte. The write strobe idles low and is pulsed high, and the chip latches the bus on the falling edge of that pulse.

Every timing minimum is a parameter in picoseconds. At elaboration it is rounded up to a whole number of system clock cycles. These minimums are:
- read access time and read pulse width;
- write pulse width, setup and hold;
- write precharge;
- the time each flag may take to settle after a strobe.

Both flags pass through a multi-flop synchronizer before use. After a strobe, each direction is locked out until its flag has settled and has crossed the synchronizer. Received bytes leave as a valid/data stream with no back-pressure. Bytes to send enter through a valid/ready stream. When both directions could go, the master alternates between them.

Top module: `fifo245_master`

## Requirements
- R1: While reset is asserted, the read strobe is high, the write strobe is low, the bus is not driven, `rx_valid` is low and `tx_ready` is low.
- R2: A read holds the read strobe low for exactly max(ceil(read access), ceil(read pulse)) cycles, which is 10 cycles at defaults with a 5 ns clock. The byte present on the bus in the last low cycle appears on `rx_data`. `rx_valid` is high for one cycle, and that cycle is the first cycle with the strobe high again.
- R3: After a read, the read strobe stays high for at least ceil(receive flag settle) + SYNC_STAGES cycles before the next read begins. That is 16 cycles at defaults.
- R4: A byte taken from the send stream is driven on the bus. The write strobe is held high for exactly max(ceil(write pulse), ceil(write setup)) cycles, which is 4 cycles at defaults. The bus is unchanged across the falling edge, and the chip captures that byte there.
- R5: The master drives the bus from the rising edge of the write strobe until exactly ceil(write hold) cycles after its falling edge, which is 2 cycles at defaults. It never drives the bus at any other time, and never while the read strobe is low.
- R6: Between a falling edge of the write strobe and its next rising edge there are at least hold + ceil(transmit flag settle) + SYNC_STAGES cycles. That is 21 cycles at defaults, which also covers the precharge minimum.
- R7: While the receive flag is high, no read starts. While the transmit flag is high, no write starts and `tx_ready` stays low. A flag that goes low after a long idle lets the read strobe fall in the third cycle after the change, because of the two-flop synchronizer.
- R8: When a read and a write are both possible, they alternate. The first grant goes to the direction that was not served last.
- R9: `tx_ready` is high only while `tx_valid` is high and a write is granted. A byte is accepted on a clock edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rx_none | input | 1 | Chip flag: high means no received byte is waiting (asynchronous) |
| ext_tx_full | input | 1 | Chip flag: high means a write is not allowed (asynchronous) |
| ext_rd_strb_n | output | 1 | Active-low read strobe to the chip |
| ext_wr_strb | output | 1 | Write strobe; the chip latches the bus on its falling edge |
| ext_data | inout | DATA_W | Shared data bus |
| ext_drive | output | 1 | High while the master drives `ext_data` |
| rx_valid | output | 1 | One-cycle pulse with a received byte |
| rx_data | output | DATA_W | Received byte |
| tx_valid | input | 1 | A byte to send is offered |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | The offered byte is taken on this edge |

## Verification
The bench measures every strobe pulse and every gap against cycle counts derived from the nanosecond minimums.
- A master that sampled the bus one cycle early, or released the read strobe too soon, would show a short read pulse or a wrong byte.
- Dropping the bus together with the write strobe would show up as a hold count of zero instead of two.
- A missing lockout would start the next strobe inside the flag settling window.

The bench also holds each flag in its blocking state and offers work. A master that ignored a flag, or raised `tx_ready` while the chip was full, would produce a strobe. It times the first read after a flag release to catch a lost or extra synchronizer stage. Finally, it raises both requests at once to confirm that read and write grants interleave.

// File: rtl/fifo245_pkg.sv
`timescale 1ns/1ps
package fifo245_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_HOLD = 2'd3
   } bus_state_t;

   // picoseconds to whole clock cycles, rounded up, never below one
   function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fifo245_sync.sv
`timescale 1ns/1ps
module fifo245_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] stage_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= RST_VAL;
               else        stage_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= RST_VAL;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/fifo245_holdoff.sv
`timescale 1ns/1ps
module fifo245_holdoff #(
   parameter int CNT_W = 8,
   parameter int LOAD  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start)      cnt_q <= CNT_W'(LOAD);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/fifo245_arb.sv
`timescale 1ns/1ps
module fifo245_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   input  logic wr_req,
   output logic gnt_rd,
   output logic gnt_wr
);

   logic last_rd_q;

   always_comb begin
      gnt_rd = 1'b0;
      gnt_wr = 1'b0;
      if (rd_req && wr_req) begin
         gnt_rd = !last_rd_q;
         gnt_wr =  last_rd_q;
      end else begin
         gnt_rd = rd_req;
         gnt_wr = wr_req;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_rd_q <= 1'b0;
      else if (gnt_rd) last_rd_q <= 1'b1;
      else if (gnt_wr) last_rd_q <= 1'b0;
   end

endmodule

// File: rtl/fifo245_master.sv
`timescale 1ns/1ps
module fifo245_master
   import fifo245_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int CLK_PS        = 5000,
   parameter int SYNC_STAGES   = 2,
   parameter int CNT_W         = 8,
   parameter int RD_ACCESS_PS  = 50000,
   parameter int RD_PULSE_PS   = 50000,
   parameter int RX_SETTLE_PS  = 67000,
   parameter int WR_PULSE_PS   = 10000,
   parameter int WR_SETUP_PS   = 20000,
   parameter int WR_HOLD_PS    = 10000,
   parameter int WR_PRECHG_PS  = 50000,
   parameter int TX_SETTLE_PS  = 84000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_rx_none,
   input  logic              ext_tx_full,
   output logic              ext_rd_strb_n,
   output logic              ext_wr_strb,
   inout  wire  [DATA_W-1:0] ext_data,
   output logic              ext_drive,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready
);

   localparam int RD_LOW_CYC  = imax(ps_to_cyc(RD_ACCESS_PS, CLK_PS),
                                     ps_to_cyc(RD_PULSE_PS, CLK_PS));
   localparam int RX_LOCK_CYC = ps_to_cyc(RX_SETTLE_PS, CLK_PS) + SYNC_STAGES;
   localparam int WR_HIGH_CYC = imax(ps_to_cyc(WR_PULSE_PS, CLK_PS),
                                     ps_to_cyc(WR_SETUP_PS, CLK_PS));
   localparam int WR_HOLD_CYC = ps_to_cyc(WR_HOLD_PS, CLK_PS);
   localparam int TX_LOCK_CYC = imax(ps_to_cyc(TX_SETTLE_PS, CLK_PS) + SYNC_STAGES,
                                     ps_to_cyc(WR_PRECHG_PS, CLK_PS) - WR_HOLD_CYC);
   localparam int WR_GAP_CYC  = WR_HOLD_CYC + TX_LOCK_CYC;
   localparam int CNT_MAX     = (1 << CNT_W) - 1;

   // elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
      if (imax(imax(RD_LOW_CYC, WR_HIGH_CYC), imax(RX_LOCK_CYC, TX_LOCK_CYC)) > CNT_MAX) begin : g_bad_cnt
         $error("CNT_W too narrow for the derived cycle counts");
      end
   endgenerate

   bus_state_t        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              rd_n_q, wr_q, drv_q, rxv_q;
   logic [DATA_W-1:0] out_q, rxd_q;
   logic              rx_none_s, tx_full_s;
   logic              rx_busy, tx_busy;
   logic              idle, rd_req, wr_req, gnt_rd, gnt_wr;
   logic              rx_lock_go, tx_lock_go;

   // flag synchronizers
   fifo245_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_rx (
      .clk(clk), .rst_n(rst_n), .d_async(ext_rx_none), .q_sync(rx_none_s));
   fifo245_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_tx (
      .clk(clk), .rst_n(rst_n), .d_async(ext_tx_full), .q_sync(tx_full_s));

   // per-direction settle lockouts
   fifo245_holdoff #(.CNT_W(CNT_W), .LOAD(RX_LOCK_CYC)) i_lock_rx (
      .clk(clk), .rst_n(rst_n), .start(rx_lock_go), .busy(rx_busy));
   fifo245_holdoff #(.CNT_W(CNT_W), .LOAD(TX_LOCK_CYC)) i_lock_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_lock_go), .busy(tx_busy));

   assign idle   = (st_q == ST_IDLE);
   assign rd_req = idle && !rx_none_s && !rx_busy;
   assign wr_req = idle && tx_valid && !tx_full_s && !tx_busy;

   fifo245_arb i_arb (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
      .gnt_rd(gnt_rd), .gnt_wr(gnt_wr));

   assign rx_lock_go = (st_q == ST_RD)   && (cnt_q == '0);
   assign tx_lock_go = (st_q == ST_HOLD) && (cnt_q == '0);

   // strobe sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         rd_n_q <= 1'b1;
         wr_q   <= 1'b0;
         drv_q  <= 1'b0;
         out_q  <= '0;
         rxv_q  <= 1'b0;
         rxd_q  <= '0;
      end else begin
         rxv_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (gnt_rd) begin
                  rd_n_q <= 1'b0;
                  cnt_q  <= CNT_W'(RD_LOW_CYC - 1);
                  st_q   <= ST_RD;
               end else if (gnt_wr) begin
                  wr_q   <= 1'b1;
                  drv_q  <= 1'b1;
                  out_q  <= tx_data;
                  cnt_q  <= CNT_W'(WR_HIGH_CYC - 1);
                  st_q   <= ST_WR;
               end
            end
            ST_RD: begin
               if (cnt_q == '0) begin
                  rd_n_q <= 1'b1;
                  rxd_q  <= ext_data;
                  rxv_q  <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  cnt_q  <= cnt_q - 1'b1;
               end
            end
            ST_WR: begin
               if (cnt_q == '0) begin
                  wr_q   <= 1'b0;
                  cnt_q  <= CNT_W'(WR_HOLD_CYC - 1);
                  st_q   <= ST_HOLD;
               end else begin
                  cnt_q  <= cnt_q - 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt_q == '0) begin
                  drv_q  <= 1'b0;
                  st_q   <= ST_IDLE;
               end else begin
                  cnt_q  <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ext_data      = drv_q ? out_q : {DATA_W{1'bz}};
   assign ext_drive     = drv_q;
   assign ext_rd_strb_n = rd_n_q;
   assign ext_wr_strb   = wr_q;
   assign rx_valid      = rxv_q;
   assign rx_data       = rxd_q;
   assign tx_ready      = gnt_wr;

endmodule

// File: rtl/fifo245_master_chk.sv
`timescale 1ns/1ps
module fifo245_master_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_n,
   input logic              wr,
   input logic              drive,
   input logic [DATA_W-1:0] bus,
   input logic              rx_valid,
   input logic              tx_valid,
   input logic              tx_ready,
   input int                min_rd,
   input int                min_rd_gap,
   input int                min_wr,
   input int                min_wr_gap
);

   logic [15:0] rd_lo_q, rd_hi_q, wr_hi_q, wr_lo_q;
   logic        rd_seen_q, wr_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_lo_q <= '0; rd_hi_q <= '0; wr_hi_q <= '0; wr_lo_q <= '0;
         rd_seen_q <= 1'b0; wr_seen_q <= 1'b0;
      end else begin
         if (!rd_n) begin
            rd_lo_q <= (rd_lo_q != '1) ? rd_lo_q + 1'b1 : rd_lo_q;
            rd_hi_q <= '0;
            rd_seen_q <= 1'b1;
         end else begin
            rd_hi_q <= (rd_hi_q != '1) ? rd_hi_q + 1'b1 : rd_hi_q;
            rd_lo_q <= '0;
         end
         if (wr) begin
            wr_hi_q <= (wr_hi_q != '1) ? wr_hi_q + 1'b1 : wr_hi_q;
            wr_lo_q <= '0;
            wr_seen_q <= 1'b1;
         end else begin
            wr_lo_q <= (wr_lo_q != '1) ? wr_lo_q + 1'b1 : wr_lo_q;
            wr_hi_q <= '0;
         end
      end
   end

   p_rd_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> int'(rd_lo_q) >= min_rd);

   p_rx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $rose(rd_n));

   p_rd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) && rd_seen_q) |-> int'(rd_hi_q) >= min_rd_gap);

   p_wr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr) |-> int'(wr_hi_q) >= min_wr);

   p_wr_fall_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr) |-> (drive && $stable(bus)));

   p_wr_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> drive);

   p_no_drive_in_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !drive);

   p_wr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr) && wr_seen_q) |-> int'(wr_lo_q) >= min_wr_gap);

   p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> tx_valid);

   p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && !rd_n));

endmodule

bind fifo245_master fifo245_master_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .rd_n(ext_rd_strb_n), .wr(ext_wr_strb),
   .drive(ext_drive), .bus(ext_data), .rx_valid(rx_valid),
   .tx_valid(tx_valid), .tx_ready(tx_ready),
   .min_rd(RD_LOW_CYC), .min_rd_gap(RX_LOCK_CYC),
   .min_wr(WR_HIGH_CYC), .min_wr_gap(WR_GAP_CYC));

// File: tb/test_fifo245_master.sv
`timescale 1ns/1ps
module test_fifo245_master;

   // expected cycle counts for a 5 ns clock, derived from the requirements
   localparam int EXP_RD_LOW  = 10;  // ceil(50/5)
   localparam int EXP_RD_GAP  = 16;  // ceil(67/5)+2
   localparam int EXP_WR_HIGH = 4;   // max(ceil(10/5), ceil(20/5))
   localparam int EXP_HOLD    = 2;   // ceil(10/5)
   localparam int EXP_WR_GAP  = 21;  // 2 + ceil(84/5) + 2
   localparam int EXP_SYNC_LAT = 3;

   // bit 8 set: write the byte; clear: read the byte
   localparam logic [8:0] VEC [0:7] = '{
      9'h05A, 9'h1A5, 9'h000, 9'h1FF, 9'h0FF, 9'h100, 9'h081, 9'h17E };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tx_full, hold_rx;
   logic       tx_valid;
   logic [7:0] tx_data;
   wire  [7:0] ext_data;
   logic       ext_rd_strb_n, ext_wr_strb, ext_drive, rx_valid, tx_ready;
   logic [7:0] rx_data;
   logic       ext_rx_none;

   logic [7:0] rxq [0:63];
   int rq_wr = 0, rq_rd = 0;
   logic [7:0] rxlog [0:63];
   logic [7:0] txlog [0:63];
   int rxcnt = 0, txcnt = 0;
   int seq [0:63];
   int nseq = 0;
   int nrd = 0, nwr = 0;
   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign ext_rx_none = hold_rx || (rq_rd == rq_wr);
   assign ext_data    = !ext_rd_strb_n ? rxq[rq_rd[5:0]] : 8'hzz;

   fifo245_master i_fifo245_master (
      .clk(clk), .rst_n(rst_n), .ext_rx_none(ext_rx_none), .ext_tx_full(tx_full),
      .ext_rd_strb_n(ext_rd_strb_n), .ext_wr_strb(ext_wr_strb), .ext_data(ext_data),
      .ext_drive(ext_drive), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bus monitor and external chip model, sampled on the falling clock edge
   bit prev_rd_low = 0, prev_wr = 0, rd_seen = 0, wr_seen = 0, hold_on = 0;
   int rd_lo = 0, rd_hi = 0, wr_hi = 0, wr_lo = 0, hold_cnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!ext_rd_strb_n) begin
            if (!prev_rd_low) begin
               chk(!ext_drive, "R5 no drive during read", int'(ext_drive), 0);
               if (rd_seen) chk(rd_hi >= EXP_RD_GAP, "R3 read gap", rd_hi, EXP_RD_GAP);
               if (nseq < 64) begin seq[nseq] = 0; nseq++; end
               nrd++;
            end
            rd_lo++;
         end else if (prev_rd_low) begin
            chk(rd_lo == EXP_RD_LOW, "R2 read strobe width", rd_lo, EXP_RD_LOW);
            rd_lo = 0; rd_hi = 1; rd_seen = 1; rq_rd++;
         end else begin
            rd_hi++;
         end
         prev_rd_low = !ext_rd_strb_n;

         if (ext_wr_strb && !prev_wr) begin
            chk(ext_drive, "R5 drive at write start", int'(ext_drive), 1);
            if (wr_seen) chk(wr_lo >= EXP_WR_GAP, "R6 write gap", wr_lo, EXP_WR_GAP);
            if (nseq < 64) begin seq[nseq] = 1; nseq++; end
            nwr++;
            wr_hi = 1;
         end else if (ext_wr_strb) begin
            wr_hi++;
         end else if (prev_wr) begin
            chk(wr_hi == EXP_WR_HIGH, "R4 write strobe width", wr_hi, EXP_WR_HIGH);
            chk(ext_drive, "R5 drive at write fall", int'(ext_drive), 1);
            txlog[txcnt[5:0]] = ext_data; txcnt++;
            wr_lo = 1; wr_seen = 1; hold_on = 1; hold_cnt = 1;
         end else begin
            wr_lo++;
            if (hold_on) begin
               if (ext_drive) hold_cnt++;
               else begin
                  chk(hold_cnt == EXP_HOLD, "R5 hold cycles", hold_cnt, EXP_HOLD);
                  hold_on = 0;
               end
            end
         end
         prev_wr = ext_wr_strb;

         if (rx_valid) begin rxlog[rxcnt[5:0]] = rx_data; rxcnt++; end
      end
   end

   task automatic push_rx(input logic [7:0] b);
      rxq[rq_wr[5:0]] = b;
      rq_wr++;
   endtask

   task automatic send_tx(input logic [7:0] b);
      tx_valid = 1'b1; tx_data = b;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (tx_ready) break;
      end
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_rx(input int target);
      for (int k = 0; k < 400 && rxcnt < target; k++) @(negedge clk);
   endtask

   task automatic wait_tx(input int target);
      for (int k = 0; k < 400 && txcnt < target; k++) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int s0, n, base_rd, base_wr, base_rx, base_tx, saw_ready;
      rst_n = 1'b0; tx_full = 1'b0; hold_rx = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ext_rd_strb_n == 1'b1, "R1 read strobe idle", int'(ext_rd_strb_n), 1);
      chk(ext_wr_strb == 1'b0, "R1 write strobe idle", int'(ext_wr_strb), 0);
      chk(ext_drive == 1'b0, "R1 bus released", int'(ext_drive), 0);
      chk(rx_valid == 1'b0, "R1 rx_valid low", int'(rx_valid), 0);
      chk(tx_ready == 1'b0, "R1 tx_ready low", int'(tx_ready), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R9 no ready without valid
      chk(tx_ready == 1'b0, "R9 ready without valid", int'(tx_ready), 0);

      // vector table: reads and writes of assorted bytes
      foreach (VEC[i]) begin
         if (VEC[i][8]) begin
            base_tx = txcnt;
            send_tx(VEC[i][7:0]);
            wait_tx(base_tx + 1);
            chk(txcnt == base_tx + 1 && txlog[base_tx[5:0]] == VEC[i][7:0],
                "R4 written byte", int'(txlog[base_tx[5:0]]), int'(VEC[i][7:0]));
         end else begin
            base_rx = rxcnt;
            push_rx(VEC[i][7:0]);
            wait_rx(base_rx + 1);
            chk(rxcnt == base_rx + 1 && rxlog[base_rx[5:0]] == VEC[i][7:0],
                "R2 read byte", int'(rxlog[base_rx[5:0]]), int'(VEC[i][7:0]));
         end
         repeat (30) @(negedge clk);
      end

      // R7 receive flag held high: data present but no read
      hold_rx = 1'b1;
      repeat (5) @(negedge clk);
      push_rx(8'hC3);
      base_rd = nrd; base_rx = rxcnt;
      repeat (40) @(negedge clk);
      chk(nrd == base_rd, "R7 no read while flag high", nrd - base_rd, 0);
      hold_rx = 1'b0;
      n = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk); n++;
         if (!ext_rd_strb_n) break;
      end
      chk(n == EXP_SYNC_LAT, "R7 synchronizer latency", n, EXP_SYNC_LAT);
      wait_rx(base_rx + 1);
      chk(rxlog[base_rx[5:0]] == 8'hC3, "R7 read after release", int'(rxlog[base_rx[5:0]]), 8'hC3);
      repeat (30) @(negedge clk);

      // R7 transmit flag held high: no write, no ready
      tx_full = 1'b1;
      repeat (5) @(negedge clk);
      base_wr = nwr; base_tx = txcnt; saw_ready = 0;
      tx_valid = 1'b1; tx_data = 8'h3C;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (tx_ready) saw_ready++;
      end
      chk(saw_ready == 0, "R7 ready held low while full", saw_ready, 0);
      chk(nwr == base_wr, "R7 no write while full", nwr - base_wr, 0);
      tx_full = 1'b0;
      send_tx(8'h3C);
      wait_tx(base_tx + 1);
      chk(txlog[base_tx[5:0]] == 8'h3C, "R7 write after release", int'(txlog[base_tx[5:0]]), 8'h3C);
      repeat (30) @(negedge clk);

      // R8 both directions ready at once
      hold_rx = 1'b1; tx_full = 1'b1;
      repeat (5) @(negedge clk);
      push_rx(8'h11); push_rx(8'h22); push_rx(8'h33); push_rx(8'h44);
      base_rx = rxcnt; base_tx = txcnt; s0 = nseq;
      hold_rx = 1'b0; tx_full = 1'b0;
      fork
         begin
            send_tx(8'hA1); send_tx(8'hB2); send_tx(8'hC3); send_tx(8'hD4);
         end
         begin
            wait_rx(base_rx + 4);
         end
      join
      wait_tx(base_tx + 4);
      chk(nseq >= s0 + 8, "R8 event count", nseq - s0, 8);
      chk(seq[s0] == 0, "R8 first grant to read", seq[s0], 0);
      n = 0;
      for (int k = 0; k < 7; k++) if (seq[s0 + k] == seq[s0 + k + 1]) n++;
      chk(n == 0, "R8 alternation", n, 0);
      chk(rxlog[base_rx[5:0]] == 8'h11 && rxlog[(base_rx + 3) & 63] == 8'h44,
          "R8 read order", int'(rxlog[(base_rx + 3) & 63]), 8'h44);
      chk(txlog[base_tx[5:0]] == 8'hA1 && txlog[(base_tx + 3) & 63] == 8'hD4,
          "R8 write order", int'(txlog[(base_tx + 3) & 63]), 8'hD4);

      repeat (10) @(negedge clk);
      chk(tx_ready == 1'b0, "R9 ready idle at end", int'(tx_ready), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule